// File: doc/BRIEF.md
# Incrementing-Stage Carry Skip Adder

A combinational binary adder of parameterised width. It splits the operands into consecutive slices called stages. The lowest stage is a plain ripple chain fed by the external carry-in. Every higher stage does two things:

- It adds its own operand slice with a carry-in tied to zero, so its ripple chain never waits for the carry from below.
- A small incrementer then folds the real incoming carry into that partial sum.

The carry passed upward from a stage comes from compound invert gates, not from a multiplexer. The carry polarity alternates from one stage to the next and is put back to true form wherever a carry is used.

A parameter selects the stage layout. In the uniform layout every stage has the same width and the top stage takes whatever bits remain. In the tapered layout the stages start narrow, grow to a peak in the middle and shrink again towards the top, which shortens the worst carry path.

Top module: `cska_ci_adder`

## Requirements
- R1: For every input, `{carry_out, sum}` equals `op_a + op_b + carry_in` computed at N+1 bits.
- R2: Every stage above the lowest computes its partial slice sum and slice carry as the slice operands added with a carry of zero.
- R3: Each higher stage's final sum bits equal its zero-carry partial sum plus the true incoming carry. The incrementer's own overflow is fed into the stage carry, and it can only be 1 when the slice fully propagates.
- R4: The carry leaving a stage is 1 exactly when the slice generates a carry internally, or when the slice propagates and the incoming carry is 1.
- R5: A slice propagates when every bit position has differing operand bits (AND of the bitwise XORs). A slice that propagates never generates an internal carry.
- R6: Carries between stages alternate polarity. The carry leaving stage 0 is inverted, and the next stage's gate restores true form. `carry_out` is always in true form, whether the stage count is even or odd.
- R7: With `VARIABLE = 0`, stage k covers bits `[k*FIX_W, k*FIX_W+FIX_W-1]`, and the top stage takes the remaining bits.
- R8: With `VARIABLE = 1`, stage k below the top is `min(2+k, VAR_STAGES+2-k)` bits wide, and the top stage takes the remaining bits. With the defaults this gives 2,3,4,5,6,5,4,3 bits.
- R9: The lowest stage uses `carry_in` directly in its ripple chain, with no incrementer.
- R10: With both operands zero, `sum` equals `carry_in` and `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| carry_out | output | 1 | Carry out of bit N-1, true polarity |

## Verification
The bench builds two 32-bit instances:

- **Tapered layout.** Eight stages, widths 2 to 6 and back to 3. An even stage count means the last carry leaves in true polarity.
- **Uniform layout, 5-bit stages.** Seven stages with a 2-bit remainder on top. An odd stage count means the final carry must be flipped back.

Between them, both restoration paths are exercised, as is a remainder stage narrower than the rest. For each layout, the bench works out the stage boundaries itself. It then places a carry generated just below each boundary in front of a fully propagating slice, so that every incrementer and every skip gate is driven to its carrying state.

// File: rtl/cska_pkg.sv
package cska_pkg;

  // width of stage k in the tapered layout (top stage excluded)
  function automatic int taper_width(int k, int vs);
    int up;
    int down;
    up   = 2 + k;
    down = vs + 2 - k;
    return (up < down) ? up : down;
  endfunction

  function automatic int stage_count(int n, int variable, int fw, int vs);
    return (variable != 0) ? vs : (n + fw - 1) / fw;
  endfunction

  function automatic int stage_lo(int k, int n, int variable, int fw, int vs);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++)
      acc += (variable != 0) ? taper_width(j, vs) : fw;
    return acc;
  endfunction

  function automatic int stage_width(int k, int n, int variable, int fw, int vs);
    int last;
    last = stage_count(n, variable, fw, vs) - 1;
    if (k == last) return n - stage_lo(k, n, variable, fw, vs);
    return (variable != 0) ? taper_width(k, vs) : fw;
  endfunction

  // true-form carry out of a stage from its generate, propagate and carry in
  function automatic logic skip_carry(logic g, logic p, logic c);
    if (g) return 1'b1;
    return p ? c : 1'b0;
  endfunction

endpackage

// File: rtl/cska_ripple.sv
module cska_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0]   cy;
  logic [W-1:0] x;

  always_comb begin
    cy[0] = cin;
    for (int i = 0; i < W; i++) begin
      x[i]      = a[i] ^ b[i];
      sum[i]    = x[i] ^ cy[i];
      cy[i+1]   = (a[i] & b[i]) | (x[i] & cy[i]);
    end
  end

  assign cout = cy[W];

  // R2: the bit-serial chain must match a word-level sum of the slice
  always_comb begin
    p_ripple_slice_r2: assert ({cout, sum} ==
                               ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("ripple slice mismatch");
  end
endmodule

// File: rtl/cska_incr.sv
module cska_incr #(
  parameter int W = 4
) (
  input  logic [W-1:0] psum,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;

  always_comb begin
    c[0] = cin;
    for (int i = 0; i < W; i++) begin
      sum[i] = psum[i] ^ c[i];
      c[i+1] = psum[i] & c[i];
    end
  end

  assign cout = c[W];

  // R3: half-adder chain equals partial sum plus the incoming carry
  always_comb begin
    p_incr_value_r3: assert ({cout, sum} == ({1'b0, psum} + {{W{1'b0}}, cin}))
      else $error("incrementer mismatch");
  end
endmodule

// File: rtl/cska_skip.sv
module cska_skip #(
  parameter int INV_IN = 0
) (
  input  logic gen,
  input  logic prop,
  input  logic cin_pol,
  output logic cout_pol
);
  logic c_true;
  logic o_true;

  if (INV_IN == 0) begin : g_aoi
    // true carry in, inverted carry out
    assign cout_pol = ~(gen | (prop & cin_pol));
    assign c_true   = cin_pol;
    assign o_true   = ~cout_pol;
  end else begin : g_oai
    // inverted carry in, true carry out
    assign cout_pol = ~((~gen) & ((~prop) | cin_pol));
    assign c_true   = ~cin_pol;
    assign o_true   = cout_pol;
  end

  // R4: compound gate equals the generate-or-propagated-carry rule
  always_comb begin
    p_skip_rule_r4: assert (o_true == cska_pkg::skip_carry(gen, prop, c_true))
      else $error("skip gate carry mismatch");
  end
endmodule

// File: rtl/cska_ci_adder.sv
module cska_ci_adder #(
  parameter int N          = 32,
  parameter int VARIABLE   = 1,
  parameter int FIX_W      = 4,
  parameter int VAR_STAGES = 8
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         carry_in,
  output logic [N-1:0] sum,
  output logic         carry_out
);
  localparam int NSTG = cska_pkg::stage_count(N, VARIABLE, FIX_W, VAR_STAGES);

  // cbus[k] is the carry into stage k; inverted when k is odd (R6)
  logic [NSTG:1] cbus;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    localparam int LO = cska_pkg::stage_lo(s, N, VARIABLE, FIX_W, VAR_STAGES);
    localparam int W  = cska_pkg::stage_width(s, N, VARIABLE, FIX_W, VAR_STAGES);

    if (s == 0) begin : g_first
      // R9: lowest stage ripples the external carry directly
      logic [W-1:0] rs;
      logic         rco;
      cska_ripple #(.W(W)) u_rip (
        .a(op_a[LO +: W]), .b(op_b[LO +: W]), .cin(carry_in),
        .sum(rs), .cout(rco)
      );
      assign sum[LO +: W] = rs;
      assign cbus[1]      = ~rco;
    end else begin : g_body
      logic [W-1:0] ps;
      logic [W-1:0] fs;
      logic         gco;
      logic         ico;
      logic         pp;
      logic         c_true;

      // R2: zero-carry ripple of the slice
      cska_ripple #(.W(W)) u_rip (
        .a(op_a[LO +: W]), .b(op_b[LO +: W]), .cin(1'b0),
        .sum(ps), .cout(gco)
      );

      // R5: slice propagate
      assign pp     = &(op_a[LO +: W] ^ op_b[LO +: W]);
      assign c_true = (s % 2 == 1) ? ~cbus[s] : cbus[s];

      // R3: fold the real carry into the partial sum
      cska_incr #(.W(W)) u_inc (
        .psum(ps), .cin(c_true), .sum(fs), .cout(ico)
      );
      assign sum[LO +: W] = fs;

      // R4/R6: polarity-alternating skip gate
      cska_skip #(.INV_IN(s % 2)) u_skp (
        .gen(gco | ico), .prop(pp), .cin_pol(cbus[s]), .cout_pol(cbus[s+1])
      );

      always_comb begin
        p_prop_no_gen_r5: assert (!(pp && gco))
          else $error("slice both propagates and generates");
        p_incr_needs_prop_r3: assert (!ico || pp)
          else $error("incrementer overflow without propagate");
      end
    end
  end

  // R6: restore true polarity at the output
  assign carry_out = (NSTG % 2 == 1) ? ~cbus[NSTG] : cbus[NSTG];

  // R1: whole-word result
  always_comb begin
    p_word_sum_r1: assert ({carry_out, sum} ==
                           ({1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in}))
      else $error("word sum mismatch");
  end
endmodule

// File: tb/cska_ci_adder_bench.sv
`timescale 1ns/1ps
module cska_ci_adder_bench;
  localparam int N = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] a, b;
  logic         ci;
  logic [N-1:0] s_var, s_fix;
  logic         co_var, co_fix;

  int checks = 0;
  int fails  = 0;

  cska_ci_adder #(.N(N), .VARIABLE(1), .FIX_W(4), .VAR_STAGES(8)) u_cska_ci_adder (
    .op_a(a), .op_b(b), .carry_in(ci), .sum(s_var), .carry_out(co_var)
  );

  cska_ci_adder #(.N(N), .VARIABLE(0), .FIX_W(5), .VAR_STAGES(8)) u_cska_ci_adder_fix (
    .op_a(a), .op_b(b), .carry_in(ci), .sum(s_fix), .carry_out(co_fix)
  );

  function automatic logic [N:0] expect_sum(logic [N-1:0] x, logic [N-1:0] y, logic c);
    logic [63:0] t;
    t = 64'(x) + 64'(y) + 64'(c);
    return t[N:0];
  endfunction

  task automatic check(string req, logic [N:0] got, logic [N:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h ci=%0b got=%h exp=%h", req, a, b, ci, got, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] x, logic [N-1:0] y, logic c, string req);
    @(posedge clk);
    a = x; b = y; ci = c;
    @(negedge clk);
    check({req, " tapered"}, {co_var, s_var}, expect_sum(x, y, c));
    check({req, " uniform"}, {co_fix, s_fix}, expect_sum(x, y, c));
  endtask

  // build a carry generated at bit lo-1 followed by a propagating slice lo..lo+w-1
  task automatic boundary(int lo, int w, string req);
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lo+i] = 1'b1;
    apply(m | (N'(1) << (lo-1)), N'(1) << (lo-1), 1'b0, req);
    apply(m, N'(1) << lo, 1'b0, req);
    apply(m, '0, 1'b1, req);
  endtask

  initial begin
    #(200000.0 * 5.0);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lo;
    int w;
    int peak_hit;
    a = '0; b = '0; ci = 1'b0;
    process::self().srandom(32'h5eed_c5ca);

    // R10: zero operands
    apply('0, '0, 1'b0, "R10");
    apply('0, '0, 1'b1, "R10");
    // R9: carry-in enters the first stage
    apply(32'h1, '0, 1'b1, "R9");
    apply(32'h3, '0, 1'b1, "R9");
    // R4/R1: all ones plus one
    apply('1, 32'h1, 1'b0, "R4");
    apply('1, '0, 1'b1, "R4");
    apply('1, '1, 1'b1, "R1");
    // R5/R6: whole-word propagate with and without carry
    apply(32'h5555_5555, 32'haaaa_aaaa, 1'b1, "R5");
    apply(32'h5555_5555, 32'haaaa_aaaa, 1'b0, "R6");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R6");

    // R8: tapered boundaries, widths ramp +1 from 2 to the peak 6 then -1
    lo = 2; w = 3; peak_hit = 0;
    for (int k = 1; k < 8; k++) begin
      if (k == 7) w = N - lo;
      boundary(lo, w, "R8");
      lo += w;
      if (w == 6) peak_hit = 1;
      w = peak_hit ? w - 1 : w + 1;
    end
    // R7: uniform 5-bit boundaries, top stage of 2 bits
    for (int k = 1; k < 7; k++) begin
      w = (k == 6) ? N - 5 * k : 5;
      boundary(5 * k, w, "R7");
    end

    // R2/R3: random vectors
    for (int i = 0; i < 3000; i++)
      apply($urandom, $urandom, 1'($urandom), "R2");
    // R3: random vectors biased to long propagate runs
    for (int i = 0; i < 1000; i++) begin
      logic [N-1:0] x;
      x = $urandom;
      apply(x, ~x ^ (N'(1) << ($urandom % N)), 1'($urandom), "R3");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule